// File: doc/BRIEF.md
# Accumulator SPI Clock Generator

This block derives the serial clock of an SPI controller from a fast reference clock. Rather than counting a whole number of reference cycles per half period, it adds a per-profile increment into an accumulator whose full scale is 2048. Every carry past full scale flips the serial clock, so each toggle is spaced by 2048 divided by the increment, on average. The ratio may be fractional. Eight profiles, one per chip select, each hold an increment, a doubling option and a reset-on-wrap option. Each profile also holds the edges on which data is launched and latched.

Configuration arrives over a simple write port. The enable input and the profile selector decide which profile drives the clock. Alongside the serial clock the block emits single-cycle launch and latch strobes that coincide with the chosen clock edges. A global polarity bit sets the idle level. A global gating bit decides whether the clock stops or keeps running while no transfer is enabled. A per-profile flag asking for the asynchronous input path is exported for the receive logic.

Top module: `acc_sclk_gen`

## Requirements
- R1: After reset, sclk, launchStb, latchStb and asyncPath are 0, every increment is 0, polarity is 0 and gating is on.
- R2: While running with reset-on-wrap clear, each reference cycle adds the step to the accumulator. A sum of 2048 or more flips sclk and keeps the remainder. After n enabled cycles, sclk equals idle level XOR bit 0 of floor(n*step/2048).
- R3: With reset-on-wrap set, the accumulator returns to zero on every carry. sclk then flips every ceil(2048/step) cycles.
- R4: With the double option set, the step is twice the increment. Any step above 2048 is limited to 2048, which flips sclk on every cycle.
- R5: A selected increment of zero stops the clock. sclk holds the idle level and no strobe is issued.
- R6: While runEn is low and gating is on, sclk holds the polarity bit as its idle level and the accumulator is cleared. Each enable therefore starts a fresh phase from idle.
- R7: With gating off, sclk keeps running from the selected profile while runEn is low, but no strobe is issued. The cycle in which runEn rises restarts the phase from idle, so the first edge after enable is a leading edge.
- R8: launchStb pulses in the same cycle as an sclk edge. It pulses on rising edges when the launch bit is set and on falling edges when it is clear.
- R9: latchStb pulses in the same cycle as an sclk edge. It pulses on rising edges when the latch bit is set and on falling edges when it is clear.
- R10: On cfgWe, cfgSpace selects the target. Space 0 is the clock control of cfgProfile: bits 13:0 increment, bit 14 double, bit 15 reset-on-wrap. Space 1 is the signal control of cfgProfile: bit 12 latch rising, bit 13 launch rising, bit 16 async path. Space 2 is global control: bit 16 gating on, bit 17 polarity. Space 3 is ignored. profSel picks which profile drives the clock, and profiles do not affect one another.
- R11: asyncPath shows the async-path bit of the profile chosen by profSel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSpace | input | 2 | Register space of the write |
| cfgProfile | input | 3 | Profile addressed by a per-profile write |
| cfgData | input | 18 | Write data |
| runEn | input | 1 | Transfer enable |
| profSel | input | 3 | Active profile |
| sclk | output | 1 | Serial clock |
| launchStb | output | 1 | Launch strobe, one cycle per selected edge |
| latchStb | output | 1 | Latch strobe, one cycle per selected edge |
| asyncPath | output | 1 | Async input path request of the active profile |

## Verification
The bench sweeps eight increments across every combination of the doubling and reset-on-wrap options. The increments are a slow 7, fractional 100, 333, 1500 and 2047, an exact 1024, full scale 2048 and an over-range 3000. Polarity, strobe edges and profile rotate across the runs. The serial clock is compared on every cycle against the arithmetic toggle count. This count tells remainder-keeping from remainder-dropping operation, shows the doubling and its saturation, and catches an off-by-one start phase. Strobes are predicted from the same count and the selected edge. The bench also runs a zero increment and a free-running disabled clock that is re-enabled against its phase. It further checks profile isolation and the async flag.

// File: rtl/asg_pkg.sv
package asg_pkg;
  localparam int ACC_FULL = 2048;
  localparam int ACC_W = $clog2(ACC_FULL) + 1;

  typedef enum logic [1:0] {
    SP_CLK  = 2'd0,
    SP_SIG  = 2'd1,
    SP_GLB  = 2'd2,
    SP_NONE = 2'd3
  } asg_space_e;

  // strobes and settings passed from control to datapath each cycle
  typedef struct packed {
    logic             run;
    logic             restart;
    logic             strobeEn;
    logic             rstOnLoop;
    logic             cpol;
    logic             launchRise;
    logic             latchRise;
    logic [ACC_W-1:0] step;
  } asg_ctl_t;
endpackage

// File: rtl/asg_ctrl.sv
module asg_ctrl
  import asg_pkg::*;
#(
  parameter int NUM_PROF = 8,
  parameter int INC_W = 14,
  parameter int DATA_W = 18,
  localparam int PW = $clog2(NUM_PROF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSpace,
  input  logic [PW-1:0]     cfgProfile,
  input  logic [DATA_W-1:0] cfgData,
  input  logic              runEn,
  input  logic [PW-1:0]     profSel,
  output asg_ctl_t          ctl,
  output logic              asyncPath
);
  localparam int BIT_X2 = 14;
  localparam int BIT_LOOP = 15;
  localparam int BIT_LATCH = 12;
  localparam int BIT_LAUNCH = 13;
  localparam int BIT_ASYNC = 16;
  localparam int BIT_GATE = 16;
  localparam int BIT_CPOL = 17;
  localparam int SC_W = INC_W + 1;

  logic [INC_W-1:0]    incQ [NUM_PROF];
  logic [NUM_PROF-1:0] x2Q, loopQ, launchQ, latchQ, asyncQ;
  logic [NUM_PROF-1:0] hit;
  logic gateQ, cpolQ, wasEnQ;

  // per-profile address decode
  for (genvar g = 0; g < NUM_PROF; g++) begin : g_dec
    assign hit[g] = cfgWe && (cfgProfile == PW'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PROF; i++) incQ[i] <= '0;
      x2Q <= '0;
      loopQ <= '0;
      launchQ <= '0;
      latchQ <= '0;
      asyncQ <= '0;
      gateQ <= 1'b1;
      cpolQ <= 1'b0;
      wasEnQ <= 1'b0;
    end else begin
      wasEnQ <= runEn;
      for (int i = 0; i < NUM_PROF; i++) begin
        if (hit[i] && cfgSpace == SP_CLK) begin
          incQ[i] <= cfgData[INC_W-1:0];
          x2Q[i] <= cfgData[BIT_X2];
          loopQ[i] <= cfgData[BIT_LOOP];
        end
        if (hit[i] && cfgSpace == SP_SIG) begin
          latchQ[i] <= cfgData[BIT_LATCH];
          launchQ[i] <= cfgData[BIT_LAUNCH];
          asyncQ[i] <= cfgData[BIT_ASYNC];
        end
      end
      if (cfgWe && cfgSpace == SP_GLB) begin
        gateQ <= cfgData[BIT_GATE];
        cpolQ <= cfgData[BIT_CPOL];
      end
    end
  end

  logic [INC_W-1:0] selInc;
  logic [SC_W-1:0]  scaled;

  always_comb begin
    selInc = incQ[profSel];
    scaled = x2Q[profSel] ? {selInc, 1'b0} : {1'b0, selInc};
    ctl.step = (scaled >= SC_W'(ACC_FULL)) ? ACC_W'(ACC_FULL) : ACC_W'(scaled);
    ctl.run = (runEn || !gateQ) && (selInc != '0);
    ctl.restart = runEn && !wasEnQ;
    ctl.strobeEn = runEn;
    ctl.rstOnLoop = loopQ[profSel];
    ctl.cpol = cpolQ;
    ctl.launchRise = launchQ[profSel];
    ctl.latchRise = latchQ[profSel];
    asyncPath = asyncQ[profSel];
  end
endmodule

// File: rtl/asg_dp.sv
module asg_dp
  import asg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  asg_ctl_t ctl,
  output logic     sclk,
  output logic     launchStb,
  output logic     latchStb
);
  logic [ACC_W-1:0] accQ, accBase, sum, nextAcc;
  logic sclkQ, launchQ, latchQ, lvlBase, carry, newLvl;

  always_comb begin
    accBase = ctl.restart ? '0 : accQ;
    lvlBase = ctl.restart ? ctl.cpol : sclkQ;
    sum = accBase + ctl.step;
    carry = sum >= ACC_W'(ACC_FULL);
    if (!carry) nextAcc = sum;
    else if (ctl.rstOnLoop) nextAcc = '0;
    else nextAcc = sum - ACC_W'(ACC_FULL);
    newLvl = lvlBase ^ carry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accQ <= '0;
      sclkQ <= 1'b0;
      launchQ <= 1'b0;
      latchQ <= 1'b0;
    end else if (!ctl.run) begin
      accQ <= '0;
      sclkQ <= ctl.cpol;
      launchQ <= 1'b0;
      latchQ <= 1'b0;
    end else begin
      accQ <= nextAcc;
      sclkQ <= newLvl;
      launchQ <= carry && ctl.strobeEn && (newLvl == ctl.launchRise);
      latchQ <= carry && ctl.strobeEn && (newLvl == ctl.latchRise);
    end
  end

  assign sclk = sclkQ;
  assign launchStb = launchQ;
  assign latchStb = latchQ;
endmodule

// File: rtl/acc_sclk_gen.sv
module acc_sclk_gen
  import asg_pkg::*;
#(
  parameter int NUM_PROF = 8,
  parameter int INC_W = 14,
  localparam int PW = $clog2(NUM_PROF),
  localparam int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSpace,
  input  logic [PW-1:0]     cfgProfile,
  input  logic [DATA_W-1:0] cfgData,
  input  logic              runEn,
  input  logic [PW-1:0]     profSel,
  output logic              sclk,
  output logic              launchStb,
  output logic              latchStb,
  output logic              asyncPath
);
  asg_ctl_t ctlS;

  asg_ctrl #(.NUM_PROF(NUM_PROF), .INC_W(INC_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgSpace(cfgSpace),
    .cfgProfile(cfgProfile), .cfgData(cfgData), .runEn(runEn),
    .profSel(profSel), .ctl(ctlS), .asyncPath(asyncPath)
  );

  asg_dp u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctlS),
    .sclk(sclk), .launchStb(launchStb), .latchStb(latchStb)
  );
endmodule

// File: rtl/asg_check.sv
module asg_check (
  input logic clk,
  input logic rst_n,
  input logic runEn,
  input logic ctlRun,
  input logic ctlCpol,
  input logic ctlLaunchRise,
  input logic ctlLatchRise,
  input logic sclk,
  input logic launchStb,
  input logic latchStb
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else armed <= 1'b1;
  end

  a_r8_launch_edge: assert property (@(posedge clk) disable iff (!rst_n)
    armed && launchStb |-> sclk != $past(sclk));
  a_r9_latch_edge: assert property (@(posedge clk) disable iff (!rst_n)
    armed && latchStb |-> sclk != $past(sclk));
  a_r8_launch_dir: assert property (@(posedge clk) disable iff (!rst_n)
    armed && launchStb |-> sclk == $past(ctlLaunchRise));
  a_r9_latch_dir: assert property (@(posedge clk) disable iff (!rst_n)
    armed && latchStb |-> sclk == $past(ctlLatchRise));
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(!ctlRun) |-> sclk == $past(ctlCpol) && !launchStb && !latchStb);
  a_r7_quiet_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(!runEn) |-> !launchStb && !latchStb);
endmodule

bind acc_sclk_gen asg_check u_chk (
  .clk(clk), .rst_n(rst_n), .runEn(runEn),
  .ctlRun(ctlS.run), .ctlCpol(ctlS.cpol),
  .ctlLaunchRise(ctlS.launchRise), .ctlLatchRise(ctlS.latchRise),
  .sclk(sclk), .launchStb(launchStb), .latchStb(latchStb)
);

// File: tb/sim_acc_sclk_gen.sv
`timescale 1ns/1ps
module sim_acc_sclk_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfgWe = 1'b0;
  logic [1:0] cfgSpace = 2'd0;
  logic [2:0] cfgProfile = 3'd0;
  logic [17:0] cfgData = '0;
  logic runEn = 1'b0;
  logic [2:0] profSel = 3'd0;
  logic sclk, launchStb, latchStb, asyncPath;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  acc_sclk_gen u0 (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgSpace(cfgSpace),
    .cfgProfile(cfgProfile), .cfgData(cfgData), .runEn(runEn),
    .profSel(profSel), .sclk(sclk), .launchStb(launchStb),
    .latchStb(latchStb), .asyncPath(asyncPath)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: run did not end, act %0d cycles exp below 150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s act %0d exp %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int space, input int prof, input int data);
    @(negedge clk);
    cfgWe = 1'b1;
    cfgSpace = 2'(space);
    cfgProfile = 3'(prof);
    cfgData = 18'(data);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // toggle count after n enabled cycles, from the requirements
  function automatic int togs(int n, int s, bit r);
    if (r) return n / ((2048 + s - 1) / s);
    return (n * s) / 2048;
  endfunction

  // run an enabled window of n cycles and compare every cycle
  task automatic runWin(input int p, input int s, input bit r, input bit cp,
                        input bit lr, input bit tr, input int n,
                        input string tag);
    int badL = 0, badS = 0;
    int aL = 0, eL = 0, aS = 0, eS = 0;
    profSel = 3'(p);
    runEn = 1'b1;
    for (int k = 1; k <= n; k++) begin
      int t, tp;
      bit lvl, tog, eLa, eLt;
      @(negedge clk);
      t = togs(k, s, r);
      tp = togs(k - 1, s, r);
      lvl = cp ^ t[0];
      tog = (t != tp);
      eLa = tog && (lvl == lr);
      eLt = tog && (lvl == tr);
      if (sclk !== lvl && badL == 0) begin aL = sclk; eL = lvl; end
      if (sclk !== lvl) badL++;
      if ((launchStb !== eLa || latchStb !== eLt) && badS == 0) begin
        aS = {launchStb, latchStb}; eS = {eLa, eLt};
      end
      if (launchStb !== eLa || latchStb !== eLt) badS++;
    end
    check(badL == 0, tag, aL, eL);
    check(badS == 0, "R8 R9 strobes {launch,latch}", aS, eS);
    runEn = 1'b0;
  endtask

  int ks[8] = '{7, 100, 333, 1024, 1500, 2047, 2048, 3000};

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(sclk === 1'b0, "R1 sclk after reset", sclk, 0);
    check(launchStb === 1'b0 && latchStb === 1'b0, "R1 strobes after reset",
          {launchStb, latchStb}, 0);
    check(asyncPath === 1'b0, "R1 asyncPath after reset", asyncPath, 0);
    rst_n = 1'b1;
    @(negedge clk);
    begin
      int bad = 0;
      profSel = 3'd0;
      runEn = 1'b1;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (sclk !== 1'b0 || launchStb || latchStb) bad++;
      end
      runEn = 1'b0;
      check(bad == 0, "R1 zero increments after reset keep sclk idle", bad, 0);
    end

    // main sweep (R2 R3 R4 R6 R8 R9 R10)
    for (int ki = 0; ki < 8; ki++) begin
      for (int r = 0; r < 2; r++) begin
        for (int x = 0; x < 2; x++) begin
          int idx, p, s;
          bit cp, lr, tr;
          string tag;
          idx = ki * 4 + r * 2 + x;
          p = idx % 8;
          cp = 1'((idx / 3) % 2);
          lr = 1'((idx / 5) % 2);
          tr = 1'((idx / 7) % 2);
          s = ks[ki] * (x ? 2 : 1);
          if (s > 2048) s = 2048;
          wr(2, 0, (int'(cp) << 17) | (1 << 16));
          wr(0, p, (r << 15) | (x << 14) | ks[ki]);
          wr(1, p, (int'(lr) << 13) | (int'(tr) << 12));
          profSel = 3'(p);
          @(negedge clk);
          @(negedge clk);
          check(sclk === cp, "R6 idle level before enable", sclk, cp);
          if (r) tag = "R3 reset-on-wrap level";
          else if (x || ks[ki] > 2048) tag = "R4 doubled/limited level";
          else tag = "R2 carry level";
          runWin(p, s, r[0], cp, lr, tr, 300, tag);
          @(negedge clk);
          check(sclk === cp && !launchStb && !latchStb, "R6 idle after disable",
                sclk, cp);
        end
      end
    end

    // R5 zero increment with polarity 1
    wr(2, 0, (1 << 17) | (1 << 16));
    wr(0, 6, 0);
    begin
      int bad = 0;
      profSel = 3'd6;
      runEn = 1'b1;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        if (sclk !== 1'b1 || launchStb || latchStb) bad++;
      end
      runEn = 1'b0;
      check(bad == 0, "R5 zero increment holds idle", bad, 0);
    end

    // R7 gating off: free run while disabled, restart on enable
    wr(0, 2, 1024);
    wr(1, 2, 1 << 13);
    profSel = 3'd2;
    wr(2, 0, 1 << 17);
    begin
      int tg = 0, st = 0;
      logic prev;
      @(negedge clk);
      prev = sclk;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (sclk !== prev) tg++;
        if (launchStb || latchStb) st++;
        prev = sclk;
      end
      check(tg == 10, "R7 free-run toggles while disabled", tg, 10);
      check(st == 0, "R7 no strobes while disabled", st, 0);
      while (sclk !== 1'b0) @(negedge clk);
      runWin(2, 1024, 1'b0, 1'b1, 1'b1, 1'b0, 10, "R7 restart phase on enable");
    end
    wr(2, 0, 1 << 16);

    // R10 profile isolation
    wr(0, 2, 2048);
    wr(1, 2, 0);
    wr(0, 5, 0);
    wr(3, 2, 0);
    runWin(2, 2048, 1'b0, 1'b0, 1'b0, 1'b0, 12, "R10 profile isolation");

    // R11 async flag follows profSel
    wr(1, 4, 1 << 16);
    wr(1, 1, 0);
    @(negedge clk);
    profSel = 3'd4;
    #1;
    check(asyncPath === 1'b1, "R11 async flag profile 4", asyncPath, 1);
    profSel = 3'd1;
    #1;
    check(asyncPath === 1'b0, "R11 async flag profile 1", asyncPath, 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule